// File: doc/BRIEF.md
# Scatter-Gather Disk DMA Engine

This block moves data between a single disk-style device port and system memory. Software builds a chain of 16-byte descriptors in memory and programs three things: the address of the first descriptor, the address of a 128-byte completion area, and a control word that carries the transfer direction and a start bit. The engine then fetches each descriptor over a request/grant memory port and moves the data one 32-bit word at a time. It keeps one running byte count for the device side and one for the memory side. After the last data word it fills the completion area with all-ones words. Software can spin on that area to learn that every data write has landed.

Software may ask for an early halt by writing the stop bit. That bit stays visible until the engine has actually quiesced at a word boundary. A memory error response on any granted access halts the engine at once and raises a sticky error flag. The next start clears that flag.

Top module: `sgdma_engine`

## Requirements
- R1: After reset every register index 0 to 8 reads zero, and no memory request or device handshake is asserted.
- R2: Register indices 0 (timing scratch), 1 (descriptor list pointer) and 8 (completion area address) read back what was written. Indices 2 and 4 (upper address halves) always read zero. Writes to indices 3 (current data address), 5 (device byte count) and 6 (memory byte count) have no effect.
- R3: The control/status register is index 7, with bit0 start, bit1 stop, bit2 direction, bit3 active and bit4 error. Start always reads 0. Writing 1 to the start bit while idle latches the direction, clears both byte counts and the error flag, and sets active.
- R4: A descriptor at address A is read as two words: the word at A+4 holds the data address and the word at A+12 holds the flags and length. Both are stored with their bytes reversed, most significant byte at the lowest address. After byte reversal, bit 31 of the second word is end-of-list and bits 15:0 are the length in bytes.
- R5: A length field of 0 means 65536 bytes.
- R6: With direction 1, words taken from the device input are written to memory at consecutive word addresses starting at the descriptor address.
- R7: With direction 0, words read from memory at consecutive word addresses are presented on the device output in order.
- R8: Each moved word adds min(4, bytes left in the descriptor) to both byte counts. After completion each count equals the sum of the descriptor lengths. The current address ends at the last descriptor address plus 4 times ceil(length/4).
- R9: If a descriptor has no end-of-list flag, the next descriptor is fetched 16 bytes further on. The descriptor carrying the flag is the last one processed.
- R10: After the last data word the engine writes 32 words of all ones at the completion area address, then clears active. Nothing beyond the final data word is written in the data buffer.
- R11: A stop written while active reads back as 1 until the engine halts at the next word or descriptor boundary. The engine then clears both stop and active, and it writes no completion area.
- R12: A memory error response on a granted access sets the error bit, clears active, and ends all further memory accesses. The word that caused the error is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Access completes in a cycle with mem_req and mem_gnt high |
| mem_rdata | input | 32 | Read data, valid with mem_gnt |
| mem_err | input | 1 | Error response, valid with mem_gnt |
| dev_in_valid | input | 1 | Device has a word for the engine |
| dev_in_data | input | 32 | Device word |
| dev_in_take | output | 1 | Engine consumes dev_in_data this cycle |
| dev_out_valid | output | 1 | Engine presents a word to the device |
| dev_out_data | output | 32 | Word for the device |
| dev_out_ready | input | 1 | Device accepts dev_out_data this cycle |

## Verification
The device-to-memory direction is swept over single-descriptor lengths of 1 to 17 bytes. This separates full words from partial last words, and it shows that the byte counts, the end address and the untouched word after the buffer each follow the length. The memory-to-device direction is swept over lengths 1 to 9 and over a three-descriptor chain, which shows the 16-byte chaining and word order. A zero length field checks the 65536-byte case. An error-responding address range and a stop issued while the device stalls show that both halt cases leave the completion area untouched, unlike a normal end. All of this runs with irregular grant and device-readiness patterns.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC_A,
        ST_DESC_L,
        ST_SRC,
        ST_DST,
        ST_MARK
    } state_e;

    // register word indices
    localparam logic [3:0] RI_TIMING  = 4'd0;
    localparam logic [3:0] RI_LIST_LO = 4'd1;
    localparam logic [3:0] RI_LIST_HI = 4'd2;
    localparam logic [3:0] RI_CUR_LO  = 4'd3;
    localparam logic [3:0] RI_CUR_HI  = 4'd4;
    localparam logic [3:0] RI_DEVCNT  = 4'd5;
    localparam logic [3:0] RI_MEMCNT  = 4'd6;
    localparam logic [3:0] RI_CTRL    = 4'd7;
    localparam logic [3:0] RI_MARK    = 4'd8;

    // control/status bit positions
    localparam int CB_START  = 0;
    localparam int CB_STOP   = 1;
    localparam int CB_DIR    = 2;
    localparam int CB_ACTIVE = 3;
    localparam int CB_ERROR  = 4;

    // descriptor layout (byte offsets inside a 16-byte entry)
    localparam int DESC_ADDR_OFS = 4;
    localparam int DESC_CTL_OFS  = 12;
    localparam int DESC_BYTES    = 16;
    localparam int EOL_BIT       = 31;

endpackage

// File: rtl/sgdma_desc_parse.sv
module sgdma_desc_parse #(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic [WORD_W-1:0] raw,
    output logic [WORD_W-1:0] swapped,
    output logic              eol,
    output logic [LEN_W:0]    bytes
);
    localparam int NBYTES = WORD_W / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_swap
        assign swapped[8*b +: 8] = raw[8*(NBYTES-1-b) +: 8];
    end

    assign eol = swapped[sgdma_pkg::EOL_BIT];

    always_comb begin
        if (swapped[LEN_W-1:0] == '0) begin
            bytes = {1'b1, {LEN_W{1'b0}}};
        end else begin
            bytes = {1'b0, swapped[LEN_W-1:0]};
        end
    end
endmodule

// File: rtl/sgdma_regfile.sv
module sgdma_regfile #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              start_pulse,
    output logic              stop_pulse,
    output logic              start_dir,
    output logic [ADDR_W-1:0] list_base,
    output logic [ADDR_W-1:0] mark_base,
    input  logic              st_active,
    input  logic              st_dir,
    input  logic              st_stop,
    input  logic              st_err,
    input  logic [ADDR_W-1:0] st_cur,
    input  logic [CNT_W-1:0]  st_devcnt,
    input  logic [CNT_W-1:0]  st_memcnt
);
    import sgdma_pkg::*;

    typedef struct packed {
        logic [31:0]       timing;
        logic [ADDR_W-1:0] list;
        logic [ADDR_W-1:0] mark;
    } rf_s;

    rf_s rf_d, rf_q;
    logic ctrl_wr;

    always_comb begin
        rf_d    = rf_q;
        ctrl_wr = reg_wr && (reg_addr == RI_CTRL);
        if (reg_wr) begin
            case (reg_addr)
                RI_TIMING:  rf_d.timing = reg_wdata;
                RI_LIST_LO: rf_d.list   = reg_wdata[ADDR_W-1:0];
                RI_MARK:    rf_d.mark   = reg_wdata[ADDR_W-1:0];
                default:    ;
            endcase
        end
        start_pulse = ctrl_wr && reg_wdata[CB_START];
        stop_pulse  = ctrl_wr && reg_wdata[CB_STOP];
        start_dir   = reg_wdata[CB_DIR];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign list_base = rf_q.list;
    assign mark_base = rf_q.mark;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RI_TIMING:  reg_rdata = rf_q.timing;
            RI_LIST_LO: reg_rdata = 32'(rf_q.list);
            RI_CUR_LO:  reg_rdata = 32'(st_cur);
            RI_DEVCNT:  reg_rdata = 32'(st_devcnt);
            RI_MEMCNT:  reg_rdata = 32'(st_memcnt);
            RI_MARK:    reg_rdata = 32'(rf_q.mark);
            RI_CTRL: begin
                reg_rdata[CB_STOP]   = st_stop;
                reg_rdata[CB_DIR]    = st_dir;
                reg_rdata[CB_ACTIVE] = st_active;
                reg_rdata[CB_ERROR]  = st_err;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sgdma_core.sv
module sgdma_core #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 32,
    parameter int LEN_W      = 16,
    parameter int MARK_BYTES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop_req,
    input  logic              start_dir,
    input  logic [ADDR_W-1:0] list_base,
    input  logic [ADDR_W-1:0] mark_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err,
    input  logic              dev_in_valid,
    input  logic [31:0]       dev_in_data,
    output logic              dev_in_take,
    output logic              dev_out_valid,
    output logic [31:0]       dev_out_data,
    input  logic              dev_out_ready,
    output logic              active,
    output logic              dir,
    output logic              stop,
    output logic              err,
    output logic [ADDR_W-1:0] cur,
    output logic [CNT_W-1:0]  devcnt,
    output logic [CNT_W-1:0]  memcnt
);
    import sgdma_pkg::*;

    localparam int MARK_WORDS = MARK_BYTES / 4;
    localparam int MIDX_W     = (MARK_WORDS > 1) ? $clog2(MARK_WORDS) : 1;
    localparam int REM_W      = LEN_W + 1;
    localparam logic [MIDX_W-1:0] MIDX_LAST = MIDX_W'(MARK_WORDS - 1);

    typedef struct packed {
        state_e            st;
        logic              dir;
        logic              stop;
        logic              err;
        logic              eol;
        logic [ADDR_W-1:0] list;
        logic [ADDR_W-1:0] cur;
        logic [REM_W-1:0]  rem;
        logic [31:0]       data;
        logic [CNT_W-1:0]  devcnt;
        logic [CNT_W-1:0]  memcnt;
        logic [MIDX_W-1:0] midx;
    } core_s;

    core_s d, q;

    logic [31:0]      p_word;
    logic             p_eol;
    logic [REM_W-1:0] p_bytes;
    logic [REM_W-1:0] step;
    logic             last_word;
    state_e           after_word;

    sgdma_desc_parse #(.WORD_W(32), .LEN_W(LEN_W)) u_parse (
        .raw     (mem_rdata),
        .swapped (p_word),
        .eol     (p_eol),
        .bytes   (p_bytes)
    );

    always_comb begin
        d             = q;
        mem_req       = 1'b0;
        mem_we        = 1'b0;
        mem_addr      = '0;
        mem_wdata     = '0;
        dev_in_take   = 1'b0;
        dev_out_valid = 1'b0;
        dev_out_data  = q.data;

        step      = (q.rem >= REM_W'(4)) ? REM_W'(4) : q.rem;
        last_word = (q.rem == step);

        // destination once the current word is done
        if (q.stop) begin
            after_word = ST_IDLE;
        end else if (!last_word) begin
            after_word = ST_SRC;
        end else if (q.eol) begin
            after_word = ST_MARK;
        end else begin
            after_word = ST_DESC_A;
        end

        if (stop_req && (q.st != ST_IDLE)) begin
            d.stop = 1'b1;
        end

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st     = ST_DESC_A;
                    d.dir    = start_dir;
                    d.err    = 1'b0;
                    d.stop   = 1'b0;
                    d.devcnt = '0;
                    d.memcnt = '0;
                    d.list   = list_base;
                end
            end

            ST_DESC_A: begin
                mem_req  = 1'b1;
                mem_addr = q.list + ADDR_W'(DESC_ADDR_OFS);
                if (mem_gnt) begin
                    if (mem_err) begin
                        d.err  = 1'b1;
                        d.st   = ST_IDLE;
                        d.stop = 1'b0;
                    end else begin
                        d.cur = p_word[ADDR_W-1:0];
                        d.st  = ST_DESC_L;
                    end
                end
            end

            ST_DESC_L: begin
                mem_req  = 1'b1;
                mem_addr = q.list + ADDR_W'(DESC_CTL_OFS);
                if (mem_gnt) begin
                    if (mem_err) begin
                        d.err  = 1'b1;
                        d.st   = ST_IDLE;
                        d.stop = 1'b0;
                    end else begin
                        d.eol = p_eol;
                        d.rem = p_bytes;
                        if (q.stop) begin
                            d.st   = ST_IDLE;
                            d.stop = 1'b0;
                        end else begin
                            d.st = ST_SRC;
                        end
                    end
                end
            end

            ST_SRC: begin
                if (q.dir) begin
                    dev_in_take = dev_in_valid;
                    if (dev_in_valid) begin
                        d.data   = dev_in_data;
                        d.devcnt = q.devcnt + CNT_W'(step);
                        d.st     = ST_DST;
                    end
                end else begin
                    mem_req  = 1'b1;
                    mem_addr = q.cur;
                    if (mem_gnt) begin
                        if (mem_err) begin
                            d.err  = 1'b1;
                            d.st   = ST_IDLE;
                            d.stop = 1'b0;
                        end else begin
                            d.data   = mem_rdata;
                            d.memcnt = q.memcnt + CNT_W'(step);
                            d.st     = ST_DST;
                        end
                    end
                end
            end

            ST_DST: begin
                if (q.dir) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = q.cur;
                    mem_wdata = q.data;
                end else begin
                    dev_out_valid = 1'b1;
                end
                if (q.dir ? mem_gnt : dev_out_ready) begin
                    if (q.dir && mem_err) begin
                        d.err  = 1'b1;
                        d.st   = ST_IDLE;
                        d.stop = 1'b0;
                    end else begin
                        if (q.dir) begin
                            d.memcnt = q.memcnt + CNT_W'(step);
                        end else begin
                            d.devcnt = q.devcnt + CNT_W'(step);
                        end
                        d.cur  = q.cur + ADDR_W'(4);
                        d.rem  = q.rem - step;
                        d.midx = '0;
                        d.st   = after_word;
                        if (after_word == ST_DESC_A) begin
                            d.list = q.list + ADDR_W'(DESC_BYTES);
                        end
                        if (after_word == ST_IDLE) begin
                            d.stop = 1'b0;
                        end
                    end
                end
            end

            ST_MARK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = mark_base + ADDR_W'({q.midx, 2'b00});
                mem_wdata = '1;
                if (mem_gnt) begin
                    if (mem_err) begin
                        d.err  = 1'b1;
                        d.st   = ST_IDLE;
                        d.stop = 1'b0;
                    end else if (q.midx == MIDX_LAST) begin
                        d.st   = ST_IDLE;
                        d.stop = 1'b0;
                    end else begin
                        d.midx = q.midx + MIDX_W'(1);
                    end
                end
            end

            default: begin
                d.st   = ST_IDLE;
                d.stop = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign active = (q.st != ST_IDLE);
    assign dir    = q.dir;
    assign stop   = q.stop;
    assign err    = q.err;
    assign cur    = q.cur;
    assign devcnt = q.devcnt;
    assign memcnt = q.memcnt;
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 32,
    parameter int LEN_W      = 16,
    parameter int MARK_BYTES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err,
    input  logic              dev_in_valid,
    input  logic [31:0]       dev_in_data,
    output logic              dev_in_take,
    output logic              dev_out_valid,
    output logic [31:0]       dev_out_data,
    input  logic              dev_out_ready
);
    logic              start_pulse;
    logic              stop_pulse;
    logic              start_dir;
    logic [ADDR_W-1:0] list_base;
    logic [ADDR_W-1:0] mark_base;
    logic              stat_active;
    logic              stat_dir;
    logic              stat_stop;
    logic              stat_err;
    logic [ADDR_W-1:0] stat_cur;
    logic [CNT_W-1:0]  stat_devcnt;
    logic [CNT_W-1:0]  stat_memcnt;

    sgdma_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse),
        .start_dir   (start_dir),
        .list_base   (list_base),
        .mark_base   (mark_base),
        .st_active   (stat_active),
        .st_dir      (stat_dir),
        .st_stop     (stat_stop),
        .st_err      (stat_err),
        .st_cur      (stat_cur),
        .st_devcnt   (stat_devcnt),
        .st_memcnt   (stat_memcnt)
    );

    sgdma_core #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .MARK_BYTES(MARK_BYTES)
    ) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start_pulse),
        .stop_req      (stop_pulse),
        .start_dir     (start_dir),
        .list_base     (list_base),
        .mark_base     (mark_base),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_gnt       (mem_gnt),
        .mem_rdata     (mem_rdata),
        .mem_err       (mem_err),
        .dev_in_valid  (dev_in_valid),
        .dev_in_data   (dev_in_data),
        .dev_in_take   (dev_in_take),
        .dev_out_valid (dev_out_valid),
        .dev_out_data  (dev_out_data),
        .dev_out_ready (dev_out_ready),
        .active        (stat_active),
        .dir           (stat_dir),
        .stop          (stat_stop),
        .err           (stat_err),
        .cur           (stat_cur),
        .devcnt        (stat_devcnt),
        .memcnt        (stat_memcnt)
    );
endmodule

// File: rtl/sgdma_engine_chk.sv
module sgdma_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_gnt,
    input logic              mem_err,
    input logic              dev_in_take,
    input logic              dev_out_valid,
    input logic              active,
    input logic              stop,
    input logic              err
);
    // R11: a pending stop only exists while the engine runs
    assert_stop_only_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop |-> active);

    // R1 / R10: an idle engine never touches memory
    assert_idle_no_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mem_req);

    // R6 / R7: a request waiting for grant is held unchanged
    assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R12: an error response halts the engine with the flag set
    assert_err_halts_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && mem_err) |=> (!active && err));

    // R7: the device port is never used in both directions at once
    assert_one_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_in_take && dev_out_valid));
endmodule

bind sgdma_engine sgdma_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_gnt       (mem_gnt),
    .mem_err       (mem_err),
    .dev_in_take   (dev_in_take),
    .dev_out_valid (dev_out_valid),
    .active        (stat_active),
    .stop          (stat_stop),
    .err           (stat_err)
);

// File: tb/sgdma_engine_test.sv
`timescale 1ns/1ps
module sgdma_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_gnt;
    logic [31:0] mem_rdata;
    logic        mem_err;
    logic        dev_in_valid;
    logic [31:0] dev_in_data;
    logic        dev_in_take;
    logic        dev_out_valid;
    logic [31:0] dev_out_data;
    logic        dev_out_ready;

    always #4 clk = ~clk;

    sgdma_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
        .dev_in_take(dev_in_take), .dev_out_valid(dev_out_valid),
        .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready)
    );

    // ---------------- memory and device models ----------------
    logic [31:0] mem [0:255];
    logic [31:0] cap [0:63];
    int          cap_n = 0;
    int          dev_idx = 0;
    int          cyc = 0;
    logic        gnt_q = 1'b0, vld_q = 1'b0, rdy_q = 1'b0;
    logic        poke_en = 1'b0;
    logic [7:0]  poke_idx = '0;
    logic [31:0] poke_dat = '0;
    logic        poison_en = 1'b0;
    logic        dev_hold = 1'b0;

    assign mem_gnt       = gnt_q;
    assign mem_rdata     = mem[mem_addr[9:2]];
    assign mem_err       = mem_req && poison_en && (mem_addr[9:8] == 2'b10);
    assign dev_in_valid  = vld_q;
    assign dev_in_data   = 32'hA000_0000 + 32'(dev_idx);
    assign dev_out_ready = rdy_q && !dev_hold;

    always @(posedge clk) begin
        cyc   <= cyc + 1;
        gnt_q <= (cyc % 5) != 2;
        vld_q <= (cyc % 3) != 1;
        rdy_q <= (cyc % 7) != 3;
        if (poke_en) begin
            mem[poke_idx] <= poke_dat;
        end else if (mem_req && mem_gnt && mem_we && !mem_err) begin
            mem[mem_addr[9:2]] <= mem_wdata;
        end
        if (dev_in_take) dev_idx <= dev_idx + 1;
        if (dev_out_valid && dev_out_ready) begin
            cap[cap_n % 64] <= dev_out_data;
            cap_n <= cap_n + 1;
        end
    end

    // ---------------- bench helpers ----------------
    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] bsw(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic wr(input logic [3:0] idx, input logic [31:0] dat);
        @(negedge clk);
        reg_addr = idx; reg_wdata = dat; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] v);
        reg_addr = idx;
        #1;
        v = reg_rdata;
    endtask

    task automatic poke(input int idx, input logic [31:0] dat);
        @(negedge clk);
        poke_en = 1'b1; poke_idx = 8'(idx); poke_dat = dat;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic put_desc(input int at, input logic [31:0] addr, input logic [31:0] ctl);
        poke(at/4 + 1, bsw(addr));
        poke(at/4 + 3, bsw(ctl));
    endtask

    task automatic clear_areas();
        for (int i = 64; i < 72; i++) poke(i, 32'h0);
        for (int i = 192; i < 224; i++) poke(i, 32'h0);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        int n;
        n = 0;
        rd(4'd7, s);
        while (s[3] && n < 100000) begin
            @(negedge clk);
            rd(4'd7, s);
            n++;
        end
    endtask

    function automatic int words_of(input int len);
        return (len + 3) / 4;
    endfunction

    task automatic check_marker(input string tag, input logic [31:0] exp);
        int ok;
        ok = 1;
        for (int i = 192; i < 224; i++) if (mem[i] !== exp) ok = 0;
        check(tag, 32'(ok), 32'd1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (195000) @(posedge clk);
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad + 1);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] v;
        int base, nw, cb;
        int lens [0:2];
        int addrs [0:2];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every register and of the ports
        for (int i = 0; i <= 8; i++) begin
            rd(4'(i), v);
            check($sformatf("R1 reg %0d after reset", i), v, 32'h0);
        end
        check("R1 no request after reset", {30'b0, mem_req, dev_in_take | dev_out_valid}, 32'h0);

        // R2: register readback behaviour
        wr(4'd0, 32'h1234_5678); rd(4'd0, v); check("R2 timing readback", v, 32'h1234_5678);
        wr(4'd2, 32'hFFFF_FFFF); rd(4'd2, v); check("R2 list high reads zero", v, 32'h0);
        wr(4'd4, 32'hFFFF_FFFF); rd(4'd4, v); check("R2 cur high reads zero", v, 32'h0);
        wr(4'd5, 32'h0000_0055); rd(4'd5, v); check("R2 dev count not writable", v, 32'h0);
        wr(4'd6, 32'h0000_0066); rd(4'd6, v); check("R2 mem count not writable", v, 32'h0);
        wr(4'd3, 32'h0000_0077); rd(4'd3, v); check("R2 cur addr not writable", v, 32'h0);
        wr(4'd8, 32'h0000_0300); rd(4'd8, v); check("R2 marker readback", v, 32'h300);
        wr(4'd1, 32'h0000_0000); rd(4'd1, v); check("R2 list readback", v, 32'h0);

        // R6 R8 R10: device to memory, single descriptor, length sweep
        for (int len = 1; len <= 17; len++) begin
            clear_areas();
            put_desc(0, 32'h100, 32'h8000_0000 | 32'(len));
            base = dev_idx;
            nw = words_of(len);
            wr(4'd7, 32'h5);
            rd(4'd7, v);
            check($sformatf("R3 active after start len=%0d", len), v, 32'h0C);
            wait_idle();
            for (int k = 0; k < nw; k++)
                check($sformatf("R6 word %0d len=%0d", k, len), mem[64 + k], 32'hA000_0000 + 32'(base + k));
            check($sformatf("R10 no overrun len=%0d", len), mem[64 + nw], 32'h0);
            rd(4'd5, v); check($sformatf("R8 dev count len=%0d", len), v, 32'(len));
            rd(4'd6, v); check($sformatf("R8 mem count len=%0d", len), v, 32'(len));
            rd(4'd3, v); check($sformatf("R8 end addr len=%0d", len), v, 32'h100 + 32'(4 * nw));
            rd(4'd7, v); check($sformatf("R10 status done len=%0d", len), v, 32'h04);
            check_marker($sformatf("R10 marker ones len=%0d", len), 32'hFFFF_FFFF);
        end

        // R7 R4: memory to device, length sweep with patterned source words
        for (int i = 64; i < 72; i++) poke(i, 32'hC000_0000 + 32'(i));
        for (int len = 1; len <= 9; len++) begin
            for (int i = 192; i < 224; i++) poke(i, 32'h0);
            put_desc(0, 32'h100, 32'h8000_0000 | 32'(len));
            cb = cap_n;
            nw = words_of(len);
            wr(4'd7, 32'h1);
            wait_idle();
            check($sformatf("R7 word count len=%0d", len), 32'(cap_n - cb), 32'(nw));
            for (int k = 0; k < nw; k++)
                check($sformatf("R7 word %0d len=%0d", k, len), cap[(cb + k) % 64], 32'hC000_0040 + 32'(k));
            rd(4'd5, v); check($sformatf("R8 dev count rd len=%0d", len), v, 32'(len));
            check_marker($sformatf("R10 marker rd len=%0d", len), 32'hFFFF_FFFF);
        end

        // R9: three-descriptor chain, memory to device
        lens[0] = 5;  addrs[0] = 32'h100;
        lens[1] = 8;  addrs[1] = 32'h180;
        lens[2] = 3;  addrs[2] = 32'h1C0;
        for (int i = 64; i < 128; i++) poke(i, 32'hC000_0000 + 32'(i));
        put_desc(0,  32'(addrs[0]), 32'(lens[0]));
        put_desc(16, 32'(addrs[1]), 32'(lens[1]));
        put_desc(32, 32'(addrs[2]), 32'h8000_0000 | 32'(lens[2]));
        cb = cap_n;
        wr(4'd7, 32'h1);
        wait_idle();
        begin
            int p;
            p = 0;
            for (int dsc = 0; dsc < 3; dsc++)
                for (int k = 0; k < words_of(lens[dsc]); k++) begin
                    check($sformatf("R9 chain desc %0d word %0d", dsc, k), cap[(cb + p) % 64],
                          32'hC000_0000 + 32'(addrs[dsc] / 4 + k));
                    p++;
                end
            check("R9 chain word total", 32'(cap_n - cb), 32'(p));
        end
        rd(4'd5, v); check("R8 chain dev count", v, 32'd16);
        rd(4'd6, v); check("R8 chain mem count", v, 32'd16);
        rd(4'd3, v); check("R8 chain end addr", v, 32'h1C4);

        // R5: zero length field means 65536 bytes
        put_desc(0, 32'h0, 32'h8000_0000);
        wr(4'd7, 32'h5);
        wait_idle();
        rd(4'd5, v); check("R5 dev count 65536", v, 32'h0001_0000);
        rd(4'd6, v); check("R5 mem count 65536", v, 32'h0001_0000);
        rd(4'd3, v); check("R5 end addr", v, 32'h0001_0000);
        check_marker("R5 marker after long run", 32'hFFFF_FFFF);

        // R12: error response on data read from the range 0x200-0x2FF
        for (int i = 192; i < 224; i++) poke(i, 32'h0);
        put_desc(0, 32'h200, 32'h8000_0008);
        poison_en = 1'b1;
        wr(4'd7, 32'h1);
        wait_idle();
        rd(4'd7, v); check("R12 error set, active clear", v, 32'h10);
        rd(4'd6, v); check("R12 failed word not counted", v, 32'h0);
        check_marker("R12 no marker after error", 32'h0);
        repeat (5) @(negedge clk);
        check("R12 no access after error", {31'b0, mem_req}, 32'h0);
        poison_en = 1'b0;
        put_desc(0, 32'h100, 32'h8000_0004);
        wr(4'd7, 32'h1);
        rd(4'd7, v); check("R3 start clears error", v, 32'h08);
        wait_idle();
        rd(4'd7, v); check("R12 clean run status", v, 32'h00);

        // R11: stop while the device stalls
        for (int i = 192; i < 224; i++) poke(i, 32'h0);
        put_desc(0, 32'h100, 32'h8000_0040);
        dev_hold = 1'b1;
        wr(4'd7, 32'h1);
        repeat (40) @(negedge clk);
        wr(4'd7, 32'h2);
        rd(4'd7, v); check("R11 stop pending reads one", v, 32'h0A);
        repeat (10) @(negedge clk);
        rd(4'd7, v); check("R11 stop held while stalled", v, 32'h0A);
        dev_hold = 1'b0;
        wait_idle();
        rd(4'd7, v); check("R11 stop and active cleared", v, 32'h00);
        rd(4'd5, v); check("R11 one word delivered", v, 32'h4);
        check_marker("R11 no marker after stop", 32'h0);

        // R11: stop while idle has no effect
        wr(4'd7, 32'h2);
        rd(4'd7, v); check("R11 stop ignored when idle", v, 32'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule